// File: doc/BRIEF.md
# Handshaked Byte-Wide Bus Slave Memory

This block is a byte-wide memory that sits on a simple processor's external bus. The bus has an 11-bit address and a shared, bidirectional 8-bit data line. The master raises the enable line and presents an address. For a write it also presents a data byte. It then pulses either the write strobe or the read strobe for two cycles and waits for the slave's busy line to fall. On a read, the master then raises output enable for one cycle and samples the byte in that same cycle. The slave drives the data line from output enable through logic only, with no register in the path. At all other times the slave leaves the line undriven.

The memory holds a boot image that is loaded before the first access. Byte `i` of the image parameter goes to address `BOOT_BASE + i`. `BOOT_BASE` defaults to 0x100, where the processor starts fetching. Reset returns the handshake logic to idle. Reset does not touch the stored bytes.

Top module: `hs_mem_slave`

## Requirements
- R1: A write strobe rising edge seen while enable is high stores the byte on the data line at the addressed location, and a later read of that address returns it.
- R2: A read strobe rising edge seen while enable is high latches the addressed byte. That byte then appears on the data line while output enable and enable are both high.
- R3: Busy goes high in the cycle after a strobe rising edge is first seen. It stays high for exactly BUSY_CYCLES cycles (default 3) and then falls.
- R4: The data line follows output enable in the same cycle, with no registered delay.
- R5: The slave does not drive the data line while output enable is low or enable is low. On the shared line the bench resolves an undriven line to 0x00.
- R6: Strobes seen while enable is low have no effect: no store and no busy.
- R7: After power-up, address BOOT_BASE+i holds bits [8i+7:8i] of BOOT_IMAGE. With the defaults, 0x100..0x103 read 0x7E, 0x81, 0x3C, 0xA5.
- R8: An active-low reset clears busy at once and releases the data line. Stored bytes survive reset.
- R9: A write strobe held high for two cycles stores exactly once, using the data present in its first high cycle. If the data changes in the second cycle, that change is not stored.
- R10: When both strobes rise in the same cycle, the write takes priority and the read latch is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Device enable from the master |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| oe_i | input | 1 | Output enable; gates the read drive |
| addr_i | input | 11 | Byte address |
| data_io | inout | 8 | Shared data line |
| busy_o | output | 1 | High while an access completes |

## Verification
On every cycle, the embedded properties check the following. Busy follows a strobe edge one cycle later. Busy falls after its last counted cycle. Every rise of busy traces back to a strobe. Each store and each read latch matches the data and address present at the strobe edge. Other behaviours only the bench's scenarios can show:
- boot contents and survival across a reset;
- capture of first-cycle data when the data changes in the second strobe cycle;
- no effect from strobes while disabled;
- write priority when both strobes rise together;
- the undriven line resolving to zero.

The bench's per-cycle model compares busy and the resolved data line throughout.

// File: rtl/hs_mem_pkg.sv
package hs_mem_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;
endpackage

// File: rtl/hs_strobe_edge.sv
module hs_strobe_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] strobe_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_q[g] <= 1'b0;
      else         strobe_q[g] <= strobe_i[g];
    end
    assign pulse_o[g] = strobe_i[g] & ~strobe_q[g] & en_i;

    // R9: one pulse per strobe, never two in a row
    p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[g] |=> !pulse_o[g]);
  end
endmodule

// File: rtl/hs_busy_timer.sv
module hs_busy_timer #(
  parameter int unsigned CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_busy_follows_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_busy_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == CW'(1) && !start_i) |=> !busy_o);
endmodule

// File: rtl/hs_mem_array.sv
module hs_mem_array
  import hs_mem_pkg::*;
#(
  parameter int unsigned AW         = 11,
  parameter int unsigned DW         = 8,
  parameter int unsigned BOOT_BASE  = 'h100,
  parameter int unsigned BOOT_LEN   = 4,
  parameter logic [DW*BOOT_LEN-1:0] BOOT_IMAGE = 32'hA53C817E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_e          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_rd;

  // boot image load; memory is never touched by reset
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    for (int i = 0; i < BOOT_LEN; i++) mem[(BOOT_BASE + i) % DEPTH] = BOOT_IMAGE[DW*i +: DW];
  end

  assign mem_rd = mem[addr_i];

  always_ff @(posedge clk_i) begin
    if (acc_i == ACC_WRITE) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (acc_i == ACC_READ) rdata_o <= mem_rd;
  end

  p_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_WRITE) |=> (mem[$past(addr_i)] == $past(wdata_i)));
  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_READ) |=> (rdata_o == $past(mem_rd)));
  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_WRITE) |=> $stable(rdata_o));
endmodule

// File: rtl/hs_mem_slave.sv
module hs_mem_slave
  import hs_mem_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter int unsigned DW          = 8,
  parameter int unsigned BUSY_CYCLES = 3,
  parameter int unsigned BOOT_BASE   = 'h100,
  parameter int unsigned BOOT_LEN    = 4,
  parameter logic [DW*BOOT_LEN-1:0] BOOT_IMAGE = 32'hA53C817E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          oe_i,
  input  logic [AW-1:0] addr_i,
  inout  wire  [DW-1:0] data_io,
  output logic          busy_o
);
  logic [1:0]    pulse;  // [0] write, [1] read
  acc_e          acc;
  logic [DW-1:0] rdata;
  logic          drive;

  hs_strobe_edge #(.N(2)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .strobe_i ({rd_i, wr_i}),
    .pulse_o  (pulse)
  );

  always_comb begin
    if (pulse[0])      acc = ACC_WRITE;
    else if (pulse[1]) acc = ACC_READ;
    else               acc = ACC_NONE;
  end

  hs_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acc != ACC_NONE),
    .busy_o  (busy_o)
  );

  hs_mem_array #(
    .AW(AW), .DW(DW), .BOOT_BASE(BOOT_BASE), .BOOT_LEN(BOOT_LEN), .BOOT_IMAGE(BOOT_IMAGE)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .addr_i  (addr_i),
    .wdata_i (data_io),
    .rdata_o (rdata)
  );

  // combinational drive so the master samples in the same cycle
  assign drive   = oe_i & en_i;
  assign data_io = drive ? rdata : {DW{1'bz}};

  p_busy_has_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_i && (rd_i || wr_i)));
  p_no_busy_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !en_i) |=> !busy_o);
endmodule

// File: tb/hs_mem_slave_test.sv
`timescale 1ns/100ps
module hs_mem_slave_test;
  localparam int BUSY = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 0, wr = 0, rd = 0, oe = 0;
  logic [10:0] addr = '0;
  logic tb_drv = 0;
  logic [7:0] tb_data = '0;
  wire  [7:0] bus;
  logic busy;

  int checks = 0, errors = 0;
  bit done = 0;

  assign bus = tb_drv ? tb_data : 8'hzz;
  for (genvar i = 0; i < 8; i++) begin : g_pd
    pulldown (bus[i]);
  end

  always #2.5 clk = ~clk;

  hs_mem_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_i(wr), .rd_i(rd), .oe_i(oe),
    .addr_i(addr), .data_io(bus), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mem [2048];
  int m_cnt = 0, m_rdata = 0;
  bit m_pw = 0, m_pr = 0;
  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    m_mem['h100] = 'h7E; m_mem['h101] = 'h81; m_mem['h102] = 'h3C; m_mem['h103] = 'hA5;
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pw = 0; m_pr = 0; m_rdata = 0;
    end else begin
      bit w, r;
      w = wr && !m_pw && en;
      r = rd && !m_pr && en;
      if (w || r) m_cnt = BUSY;
      else if (m_cnt > 0) m_cnt--;
      if (w) m_mem[addr] = bus;
      else if (r) m_rdata = m_mem[addr];
      m_pw = wr; m_pr = rd;
    end
  end

  // per-cycle compare: R3 busy, R4/R5 data line
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 busy", busy, (m_cnt != 0) ? 1 : 0);
      if (!tb_drv) chk("R4 R5 bus", bus, (oe && en) ? m_rdata : 0);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_idle();
    step(1);
    while (busy) step(1);
  endtask

  task automatic do_write(logic [10:0] a, logic [7:0] d);
    en = 1; addr = a; tb_data = d; tb_drv = 1;
    step(2);
    wr = 1; step(2); wr = 0; step(2);
    while (busy) step(1);
    tb_drv = 0;
    step(1);
  endtask

  task automatic do_read(logic [10:0] a, int exp, string req);
    en = 1; addr = a;
    step(2);
    rd = 1; step(2); rd = 0; step(2);
    while (busy) step(1);
    oe = 1;
    #0.5 chk(req, bus, exp);  // same cycle as oe rises: R4
    step(1);
    oe = 0;
    step(1);
  endtask

  initial begin
    step(2);
    @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset bus", bus, 0);
    rst_n = 1;
    step(1);

    // R7 boot contents
    do_read('h100, 'h7E, "R7 boot0");
    do_read('h101, 'h81, "R7 boot1");
    do_read('h102, 'h3C, "R7 boot2");
    do_read('h103, 'hA5, "R7 boot3");

    // R1 store/readback, incl. top address; R2 read path
    do_write('h010, 'h5A);
    do_read('h010, 'h5A, "R1 R2 readback");
    do_write('h7FF, 'hC7);
    do_read('h7FF, 'hC7, "R1 top address");

    // R9 data changed in second strobe cycle is not stored
    en = 1; addr = 'h020; tb_data = 'h11; tb_drv = 1; step(2);
    wr = 1; step(1); tb_data = 'h99; step(1); wr = 0; step(2);
    while (busy) step(1);
    tb_drv = 0; step(1);
    do_read('h020, 'h11, "R9 first-cycle data");

    // R3 busy timing from a single strobe edge
    en = 1; addr = 'h010; step(2);
    rd = 1; step(1);
    @(negedge clk); chk("R3 busy rises", busy, 1);
    step(1); rd = 0; step(BUSY);
    @(negedge clk); chk("R3 busy falls", busy, 0);
    step(1);

    // R6 strobes with enable low
    en = 0; addr = 'h010; tb_data = 'hC3; tb_drv = 1; step(2);
    wr = 1; step(2); wr = 0;
    @(negedge clk); chk("R6 no busy", busy, 0);
    tb_drv = 0; step(1);
    rd = 1; step(2); rd = 0;
    @(negedge clk); chk("R6 no busy rd", busy, 0);
    step(1);
    do_read('h010, 'h5A, "R6 no store");

    // R5 release: oe low with en high, and oe high with en low
    en = 1; oe = 0; step(1);
    @(negedge clk); chk("R5 oe low", bus, 0);
    en = 0; oe = 1; step(1);
    @(negedge clk); chk("R5 en low", bus, 0);
    oe = 0; step(1);

    // R10 both strobes rise together: the write wins
    en = 1; addr = 'h030; tb_data = 'h3E; tb_drv = 1; step(2);
    wr = 1; rd = 1; step(2); wr = 0; rd = 0; step(2);
    while (busy) step(1);
    tb_drv = 0;
    oe = 1;
    #0.5 chk("R10 latch unchanged", bus, 'h5A);
    step(1); oe = 0; step(1);
    do_read('h030, 'h3E, "R10 write done");

    // R8 reset mid-busy, memory kept
    en = 1; addr = 'h010; step(2);
    rd = 1; step(2); rd = 0;
    @(negedge clk); chk("R8 busy before reset", busy, 1);
    #0.5 rst_n = 0;
    #0.5 chk("R8 busy cleared", busy, 0);
    step(2);
    rst_n = 1; step(1);
    do_read('h010, 'h5A, "R8 memory kept");
    do_read('h101, 'h81, "R8 boot kept");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule